// File: doc/BRIEF.md
# Card-Detect Control Register Block

This block is a small board-control register file on a word-addressed register bus. It returns an identification word, a flash-programming word and an address-decode status word, and it holds one live interrupt register. That register follows the memory-card write-protect level and remembers a card insertion. A card insertion stays latched until software clears it.

The latched insertion bit drives the interrupt line of the card controller directly. Software can read the line's state from the interrupt register and acknowledge it by writing a one to the same bit position. Read data is registered and appears on the cycle after the read request. Accesses to indices the block does not map read as zero, change nothing and raise a one-cycle error pulse.

Top module: `cardslot_ctrl_regs`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `card_irq`, `rsp_err`, `rsp_rdata` and both flags of the interrupt register are zero.
- R2: A read request at word index 0 returns 0x41034003, index 1 returns 0 and index 3 returns 0x00000011. Read data appears on `rsp_rdata` on the cycle after the request and holds its value until the next read.
- R3: Bit 0 of the interrupt register (index 2) is the `wp_level` input sampled at the previous clock edge. A high level sets it and a low level clears it.
- R4: `card_in` high at a clock edge sets bit 3 of the interrupt register. `card_in` low never clears it.
- R5: A write to index 2 whose data has bit 3 set clears bit 3. A write with bit 3 clear changes nothing, and no write changes bit 0.
- R6: When `card_in` is high on the same edge as a clearing write, bit 3 stays set.
- R7: `card_irq` equals bit 3 of the interrupt register at all times.
- R8: Writes to index 1 and index 3 are accepted and have no effect on any register, on `card_irq`, or on the values later read.
- R9: A read or write at an index of 4 or above reads as zero and changes no state. It drives `rsp_err` high for exactly the one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Word index of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, registered, valid the cycle after a read |
| rsp_err | output | 1 | One-cycle pulse after an unmapped access |
| wp_level | input | 1 | Card write-protect level from the slot |
| card_in | input | 1 | Card-inserted indication from the slot |
| card_irq | output | 1 | Interrupt to the card controller, equal to the latched insertion bit |

## Verification
Every result of this block is due exactly one clock edge after its cause. Read data and the error pulse follow the request edge. Interrupt-register bits and `card_irq` follow the edge at which `card_in`, `wp_level` or a clearing write is sampled. A read of index 2 returns the flags as they stood before that same edge.

The bench drives stimulus on the falling edge. Its reference model advances on the rising edge, using the same sampled inputs. All three outputs are compared against the model on the following falling edge, so each expected value is looked up only after the register that produces it has been clocked.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

    // Fixed read-only words
    localparam logic [31:0] IDENT_WORD  = 32'h4103_4003;
    localparam logic [31:0] DECODE_WORD = 32'h0000_0011;

    // Word indices; software decodes these positions
    localparam int IDX_IDENT   = 0;
    localparam int IDX_FLASH   = 1;
    localparam int IDX_INTREG  = 2;
    localparam int IDX_DECODE  = 3;
    localparam int NUM_MAPPED  = 4;

    // Bit positions inside the interrupt register
    localparam int WP_BIT   = 0;
    localparam int CARD_BIT = 3;

    typedef enum logic [2:0] {
        RG_IDENT,
        RG_FLASH,
        RG_INTREG,
        RG_DECODE,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic wp;
        logic card;
    } flags_t;

endpackage

// File: rtl/cslot_decode.sv
module cslot_decode
    import cslot_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic             wdata_card_bit,
    output region_e          region,
    output logic             rd_en,
    output logic             clr_card,
    output logic             bad_access
);

    always_comb begin
        case (int'(req_index))
            IDX_IDENT:  region = RG_IDENT;
            IDX_FLASH:  region = RG_FLASH;
            IDX_INTREG: region = RG_INTREG;
            IDX_DECODE: region = RG_DECODE;
            default:    region = RG_NONE;
        endcase
    end

    always_comb begin
        rd_en      = req_valid && !req_write;
        clr_card   = req_valid && req_write && (region == RG_INTREG) && wdata_card_bit;
        bad_access = req_valid && (region == RG_NONE);
    end

endmodule

// File: rtl/cslot_intreg.sv
module cslot_intreg
    import cslot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wp_level,
    input  logic              card_in,
    input  logic              clr_card,
    output logic [DATA_W-1:0] intreg,
    output logic              irq
);

    flags_t flags_d, flags_q;

    always_comb begin
        flags_d      = flags_q;
        flags_d.wp   = wp_level;
        // A set from the slot wins over a software clear on the same edge
        flags_d.card = card_in | (flags_q.card & ~clr_card);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        intreg           = '0;
        intreg[WP_BIT]   = flags_q.wp;
        intreg[CARD_BIT] = flags_q.card;
    end

    assign irq = flags_q.card;

endmodule

// File: rtl/cslot_readback.sv
module cslot_readback
    import cslot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en,
    input  region_e           region,
    input  logic              bad_access,
    input  logic [DATA_W-1:0] intreg,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.err = bad_access;
        if (rd_en) begin
            case (region)
                RG_IDENT:  rsp_d.rdata = DATA_W'(IDENT_WORD);
                RG_FLASH:  rsp_d.rdata = '0;
                RG_INTREG: rsp_d.rdata = intreg;
                RG_DECODE: rsp_d.rdata = DATA_W'(DECODE_WORD);
                default:   rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rdata = rsp_q.rdata;
    assign err   = rsp_q.err;

endmodule

// File: rtl/cardslot_ctrl_regs.sv
module cardslot_ctrl_regs
    import cslot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              wp_level,
    input  logic              card_in,
    output logic              card_irq
);

    region_e           region;
    logic              rd_en;
    logic              clr_card;
    logic              bad_access;
    logic [DATA_W-1:0] intreg;

    cslot_decode #(.IDX_W(IDX_W)) i_decode (
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_index      (req_index),
        .wdata_card_bit (req_wdata[CARD_BIT]),
        .region         (region),
        .rd_en          (rd_en),
        .clr_card       (clr_card),
        .bad_access     (bad_access)
    );

    cslot_intreg #(.DATA_W(DATA_W)) i_intreg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wp_level (wp_level),
        .card_in  (card_in),
        .clr_card (clr_card),
        .intreg   (intreg),
        .irq      (card_irq)
    );

    cslot_readback #(.DATA_W(DATA_W)) i_readback (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en      (rd_en),
        .region     (region),
        .bad_access (bad_access),
        .intreg     (intreg),
        .rdata      (rsp_rdata),
        .err        (rsp_err)
    );

endmodule

// File: rtl/cslot_regs_checker.sv
module cslot_regs_checker
    import cslot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W-1:0]  req_index,
    input logic              wbit_card,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              wp_level,
    input logic              card_in,
    input logic              card_irq
);

    logic [1:0] since_rst;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    logic clr_wr, is_read, unmapped;
    assign clr_wr   = req_valid && req_write && (int'(req_index) == IDX_INTREG) && wbit_card;
    assign is_read  = req_valid && !req_write;
    assign unmapped = req_valid && (int'(req_index) >= NUM_MAPPED);

    // R4 / R6: slot set wins, including over a clearing write
    a_r4_set_on_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        card_in |=> card_irq);

    // R4 / R7: latch holds without an acknowledge
    a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (card_irq && !clr_wr) |=> card_irq);

    // R5: acknowledge clears when the slot is quiet
    a_r5_clear_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && !card_in) |=> !card_irq);

    // R7: the line only rises from a slot indication
    a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!card_irq && !card_in) |=> !card_irq);

    // R9: error pulse follows exactly the unmapped accesses
    a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unmapped |=> rsp_err);
    a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !unmapped |=> !rsp_err);
    a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unmapped && !req_write) |=> (rsp_rdata == '0));

    // R2: fixed words
    a_r2_ident: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_read && int'(req_index) == IDX_IDENT) |=> (rsp_rdata == DATA_W'(IDENT_WORD)));
    a_r2_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_read && int'(req_index) == IDX_DECODE) |=> (rsp_rdata == DATA_W'(DECODE_WORD)));
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst != 2'd0 && !is_read) |=> $stable(rsp_rdata));

    // R3 / R7: readback of the interrupt register
    a_r3_wp_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2 && is_read && int'(req_index) == IDX_INTREG)
            |=> (rsp_rdata[WP_BIT] == $past(wp_level, 2)));
    a_r7_card_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_read && int'(req_index) == IDX_INTREG) |=> (rsp_rdata[CARD_BIT] == $past(card_irq)));

endmodule

bind cardslot_ctrl_regs cslot_regs_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_index (req_index),
    .wbit_card (req_wdata[cslot_pkg::CARD_BIT]),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .wp_level  (wp_level),
    .card_in   (card_in),
    .card_irq  (card_irq)
);

// File: tb/test_cardslot_ctrl_regs.sv
`timescale 1ns/1ps
module test_cardslot_ctrl_regs;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [IDX_W-1:0]  req_index = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_err;
    logic              wp_level = 1'b0;
    logic              card_in = 1'b0;
    logic              card_irq;

    always #2.5 clk = ~clk;

    cardslot_ctrl_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_cardslot_ctrl_regs (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .wp_level  (wp_level),
        .card_in   (card_in),
        .card_irq  (card_irq)
    );

    // Behavioural reference model
    bit        m_wp, m_card, m_err;
    bit [31:0] m_rdata;
    integer    n_cmp = 0;
    integer    n_bad = 0;
    string     tag = "R1";
    bit        done = 1'b0;

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_wp = 0; m_card = 0; m_err = 0; m_rdata = 0;
        end else begin
            if (req_valid && !req_write) begin
                if (req_index == 0)      m_rdata = 32'h4103_4003;
                else if (req_index == 2) m_rdata = (m_card ? 32'h8 : 32'h0) | (m_wp ? 32'h1 : 32'h0);
                else if (req_index == 3) m_rdata = 32'h11;
                else                     m_rdata = 32'h0;
            end
            m_err  = req_valid && (req_index >= 4);
            m_card = card_in || (m_card && !(req_valid && req_write && req_index == 2 && req_wdata[3]));
            m_wp   = wp_level;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp = n_cmp + 3;
            if (card_irq !== m_card) begin
                n_bad++;
                $display("FAIL %s card_irq actual=%0b expected=%0b at %0t", tag, card_irq, m_card, $time);
            end
            if (rsp_err !== m_err) begin
                n_bad++;
                $display("FAIL %s rsp_err actual=%0b expected=%0b at %0t", tag, rsp_err, m_err, $time);
            end
            if (rsp_rdata !== m_rdata) begin
                n_bad++;
                $display("FAIL %s rsp_rdata actual=%h expected=%h at %0t", tag, rsp_rdata, m_rdata, $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            req_valid = 0;
            @(negedge clk);
        end
    endtask

    task automatic acc(input bit wr, input int idx, input logic [31:0] wd);
        req_valid = 1; req_write = wr; req_index = IDX_W'(idx); req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_wdata = '0;
    endtask

    initial begin
        // R1: reset state, including with slot inputs active
        tag = "R1";
        wp_level = 1; card_in = 1;
        repeat (3) @(negedge clk);
        wp_level = 0; card_in = 0;
        rst_ni = 1;
        idle(2);

        // R2: fixed words and hold between reads
        tag = "R2";
        acc(0, 0, 0); idle(2);
        acc(0, 1, 0); idle(1);
        acc(0, 3, 0); idle(3);
        acc(1, 2, 32'h0); idle(1);

        // R3: write-protect follows the level
        tag = "R3";
        wp_level = 1; idle(1); acc(0, 2, 0); acc(0, 2, 0);
        wp_level = 0; acc(0, 2, 0); acc(0, 2, 0);
        wp_level = 1; idle(1); acc(0, 2, 0);

        // R4: insertion sets, release does not clear
        tag = "R4";
        card_in = 1; @(negedge clk); card_in = 0;
        idle(3); acc(0, 2, 0); idle(1);

        // R7: interrupt line mirrors bit 3 over a long hold
        tag = "R7";
        idle(10); acc(0, 2, 0);

        // R5: writes without bit 3 do nothing, bit 3 write clears
        tag = "R5";
        acc(1, 2, 32'h0000_0001); acc(1, 2, 32'hFFFF_FFF7); acc(0, 2, 0);
        acc(1, 2, 32'h0000_0008); acc(0, 2, 0); idle(2);

        // R6: set wins over a simultaneous clear
        tag = "R6";
        card_in = 1; acc(1, 2, 32'h8); card_in = 0;
        acc(0, 2, 0); acc(1, 2, 32'h8); acc(0, 2, 0);

        // R8: writes to flash and decode words are ignored
        tag = "R8";
        card_in = 1; @(negedge clk); card_in = 0;
        acc(1, 1, 32'hFFFF_FFFF); acc(1, 3, 32'hFFFF_FFFF);
        acc(0, 1, 0); acc(0, 3, 0); acc(0, 2, 0);

        // R9: unmapped indices
        tag = "R9";
        for (int k = 4; k < 16; k++) begin
            acc(1, k, 32'hFFFF_FFFF);
            acc(0, k, 0);
            idle(1);
        end
        acc(0, 2, 0); acc(1, 2, 32'h8); acc(0, 2, 0); idle(1);

        // R5: random mix against the model
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            wp_level  = 1'($urandom);
            card_in   = (($urandom % 8) == 0);
            req_valid = 1'($urandom);
            req_write = 1'($urandom);
            req_index = IDX_W'($urandom);
            req_wdata = $urandom;
            @(negedge clk);
        end
        req_valid = 0; card_in = 0;
        idle(3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired in %s", tag);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule